// File: doc/BRIEF.md
# Clock-Profile Coincidence Window Unit

This unit converts a five-bit clock-phase profile and a fine delay word into a timing window, with a start and a stop edge counted in 10 ps ticks. The profile is walked in five 5 ns steps. The first set bit opens the window, and the first clear bit after it closes the window. A window that never closes ends at 30 ns. The delay word then shifts both edges later, one tick per unit, and each sum saturates at the top of the time range.

Once loaded, the window is used in two ways. Each strobed hit timestamp is tested against it, and a registered coincidence pulse reports the result. The window is also combined with a second window supplied on the ports. The combine operation is either a union (earliest start, latest stop) or an intersection (latest start, earliest stop). A separate flag marks the case where the two windows share no time at all, and the combined edges are still produced in that case.

Top module: `cpwin_unit`

## Requirements
- R1: The profile is examined in step order 1..5 reading bit 3, bit 2, bit 1, bit 0, then bit 4. The start edge is 500 ticks times the number of the first step whose bit is 1. Later set bits leave it unchanged.
- R2: After the start is found, the first step whose bit is 0 sets the stop edge to 500 ticks times that step's number. Later clear bits are ignored.
- R3: If no clear bit follows the start, the stop edge is 3000 ticks. An all-zero profile gives start 0 and stop 3000.
- R4: The delay word is added to both edges, one tick per unit. A sum above 65535 saturates at 65535.
- R5: `win_start_o` and `win_stop_o` take the decoded values one clock after a cycle with `load_i` high, and hold their value in every other cycle.
- R6: One clock after a cycle with `hit_valid_i` high, `coinc_o` is 1 exactly when `hit_time_i` is strictly greater than the window start and strictly less than the window stop held in that cycle. `coinc_o` is 0 one clock after any cycle without a valid hit.
- R7: With `op_and_i` = 0, the merged start is the smaller of the two starts and the merged stop is the larger of the two stops.
- R8: With `op_and_i` = 1, the merged start is the larger of the two starts and the merged stop is the smaller of the two stops.
- R9: `disjoint_o` is 1 exactly when either window's start is greater than the other window's stop. Windows that only touch are not disjoint. The merged edges are produced unchanged when the flag is set.
- R10: While reset is asserted and after its release, the window edges and `coinc_o` are 0 until the first load or hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture a new window from profile and delay |
| profile_i | input | 5 | Clock-phase profile |
| delay_i | input | 16 | Fine delay, one tick per unit |
| hit_valid_i | input | 1 | Hit timestamp strobe |
| hit_time_i | input | 16 | Hit timestamp in ticks |
| other_start_i | input | 16 | Second window start |
| other_stop_i | input | 16 | Second window stop |
| op_and_i | input | 1 | 0 selects union, 1 selects intersection |
| win_start_o | output | 16 | Held window start |
| win_stop_o | output | 16 | Held window stop |
| mrg_start_o | output | 16 | Combined window start |
| mrg_stop_o | output | 16 | Combined window stop |
| coinc_o | output | 1 | Registered coincidence pulse |
| disjoint_o | output | 1 | Windows have no common time |

## Verification
A window load and a hit strobe can arrive in the same cycle. In that case the hit must be judged against the window that is already held, not the one being captured. The bench raises `load_i` with a new profile in the same cycle as a valid hit. It queues an expectation computed from the old edges, and it checks the next hit against the new edges. The bench also judges hits one tick on each side of both edges, so that the strict comparisons are exercised.

// File: rtl/cpwin_pkg.sv
package cpwin_pkg;

   localparam int unsigned PROF_W = 5;

   // step s (0-based) reads profile bit 3,2,1,0 then 4
   function automatic int unsigned scan_bit(input int unsigned step);
      return (step < PROF_W - 1) ? (PROF_W - 2 - step) : (PROF_W - 1);
   endfunction

endpackage

// File: rtl/cpwin_decode.sv
module cpwin_decode
   import cpwin_pkg::*;
#(
   parameter int unsigned TIME_W     = 16,
   parameter int unsigned STEP_TICKS = 500,
   parameter int unsigned DEF_STOP   = 3000
) (
   input  logic [PROF_W-1:0] profile_i,
   output logic [TIME_W-1:0] start_o,
   output logic [TIME_W-1:0] stop_o
);

   logic rise;
   logic fall;
   logic bit_v;

   always_comb begin
      rise    = 1'b0;
      fall    = 1'b0;
      bit_v   = 1'b0;
      start_o = '0;
      stop_o  = TIME_W'(DEF_STOP);
      for (int unsigned s = 0; s < PROF_W; s++) begin
         bit_v = profile_i[scan_bit(s)];
         if (bit_v && !rise) begin
            start_o = TIME_W'(STEP_TICKS * (s + 1));
            rise    = 1'b1;
         end else if (!bit_v && rise && !fall) begin
            stop_o = TIME_W'(STEP_TICKS * (s + 1));
            fall   = 1'b1;
         end
      end
   end

endmodule

// File: rtl/cpwin_satadd.sv
module cpwin_satadd #(
   parameter int unsigned TIME_W = 16,
   parameter int unsigned DLY_W  = 16
) (
   input  logic [TIME_W-1:0] edge_i,
   input  logic [DLY_W-1:0]  delay_i,
   output logic [TIME_W-1:0] edge_o
);

   localparam int unsigned SUM_W = TIME_W + 1;

   logic [SUM_W-1:0] sum;

   assign sum    = {1'b0, edge_i} + SUM_W'(delay_i);
   assign edge_o = sum[TIME_W] ? {TIME_W{1'b1}} : sum[TIME_W-1:0];

endmodule

// File: rtl/cpwin_merge.sv
module cpwin_merge #(
   parameter int unsigned TIME_W = 16
) (
   input  logic [TIME_W-1:0] a_start_i,
   input  logic [TIME_W-1:0] a_stop_i,
   input  logic [TIME_W-1:0] b_start_i,
   input  logic [TIME_W-1:0] b_stop_i,
   input  logic              op_and_i,
   output logic [TIME_W-1:0] start_o,
   output logic [TIME_W-1:0] stop_o,
   output logic              disjoint_o
);

   logic a_first;
   logic a_last;

   assign a_first    = a_start_i < b_start_i;
   assign a_last     = a_stop_i > b_stop_i;
   assign start_o    = (op_and_i ^ a_first) ? a_start_i : b_start_i;
   assign stop_o     = (op_and_i ^ a_last)  ? a_stop_i  : b_stop_i;
   assign disjoint_o = (a_start_i > b_stop_i) || (b_start_i > a_stop_i);

endmodule

// File: rtl/cpwin_unit.sv
module cpwin_unit
   import cpwin_pkg::*;
#(
   parameter int unsigned TIME_W     = 16,
   parameter int unsigned DLY_W      = 16,
   parameter int unsigned STEP_TICKS = 500,
   parameter int unsigned DEF_STOP   = 3000,
   parameter bit          MERGE_REG  = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [4:0]        profile_i,
   input  logic [DLY_W-1:0]  delay_i,
   input  logic              hit_valid_i,
   input  logic [TIME_W-1:0] hit_time_i,
   input  logic [TIME_W-1:0] other_start_i,
   input  logic [TIME_W-1:0] other_stop_i,
   input  logic              op_and_i,
   output logic [TIME_W-1:0] win_start_o,
   output logic [TIME_W-1:0] win_stop_o,
   output logic [TIME_W-1:0] mrg_start_o,
   output logic [TIME_W-1:0] mrg_stop_o,
   output logic              coinc_o,
   output logic              disjoint_o
);

   localparam int unsigned NEDGE   = 2;
   localparam longint      T_RANGE = longint'(1) << TIME_W;

   if (DEF_STOP >= T_RANGE || STEP_TICKS * PROF_W >= T_RANGE) begin : g_bad_range
      $error("cpwin_unit: TIME_W too narrow for step or default stop");
   end
   if (DLY_W > TIME_W) begin : g_bad_dly
      $error("cpwin_unit: DLY_W must not exceed TIME_W");
   end
   if (PROF_W != 5) begin : g_bad_prof
      $error("cpwin_unit: profile width must be 5");
   end

   logic [TIME_W-1:0] raw_edge [NEDGE];
   logic [TIME_W-1:0] adj_edge [NEDGE];
   logic [TIME_W-1:0] start_q, stop_q;
   logic              coinc_q;
   logic [TIME_W-1:0] m_start, m_stop;
   logic              m_disj;

   cpwin_decode #(
      .TIME_W    (TIME_W),
      .STEP_TICKS(STEP_TICKS),
      .DEF_STOP  (DEF_STOP)
   ) u_decode (
      .profile_i(profile_i),
      .start_o  (raw_edge[0]),
      .stop_o   (raw_edge[1])
   );

   for (genvar e = 0; e < NEDGE; e++) begin : g_edge
      cpwin_satadd #(
         .TIME_W(TIME_W),
         .DLY_W (DLY_W)
      ) u_add (
         .edge_i (raw_edge[e]),
         .delay_i(delay_i),
         .edge_o (adj_edge[e])
      );
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         start_q <= '0;
         stop_q  <= '0;
         coinc_q <= 1'b0;
      end else begin
         if (load_i) begin
            start_q <= adj_edge[0];
            stop_q  <= adj_edge[1];
         end
         coinc_q <= hit_valid_i && (hit_time_i > start_q) && (hit_time_i < stop_q);
      end
   end

   cpwin_merge #(
      .TIME_W(TIME_W)
   ) u_merge (
      .a_start_i (start_q),
      .a_stop_i  (stop_q),
      .b_start_i (other_start_i),
      .b_stop_i  (other_stop_i),
      .op_and_i  (op_and_i),
      .start_o   (m_start),
      .stop_o    (m_stop),
      .disjoint_o(m_disj)
   );

   if (MERGE_REG) begin : g_merge_reg
      logic [TIME_W-1:0] ms_q, mt_q;
      logic              md_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            ms_q <= '0;
            mt_q <= '0;
            md_q <= 1'b0;
         end else begin
            ms_q <= m_start;
            mt_q <= m_stop;
            md_q <= m_disj;
         end
      end
      assign mrg_start_o = ms_q;
      assign mrg_stop_o  = mt_q;
      assign disjoint_o  = md_q;
   end else begin : g_merge_comb
      assign mrg_start_o = m_start;
      assign mrg_stop_o  = m_stop;
      assign disjoint_o  = m_disj;
   end

   assign win_start_o = start_q;
   assign win_stop_o  = stop_q;
   assign coinc_o     = coinc_q;

endmodule

// File: rtl/cpwin_unit_chk.sv
module cpwin_unit_chk #(
   parameter int unsigned TIME_W    = 16,
   parameter bit          MERGE_REG = 1'b0
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              load_i,
   input logic              hit_valid_i,
   input logic [TIME_W-1:0] hit_time_i,
   input logic [TIME_W-1:0] other_start_i,
   input logic [TIME_W-1:0] other_stop_i,
   input logic              op_and_i,
   input logic [TIME_W-1:0] win_start_o,
   input logic [TIME_W-1:0] win_stop_o,
   input logic [TIME_W-1:0] mrg_start_o,
   input logic [TIME_W-1:0] mrg_stop_o,
   input logic              coinc_o,
   input logic              disjoint_o
);

   p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(win_start_o) && $stable(win_stop_o));

   p_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      win_start_o <= win_stop_o);

   p_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_valid_i |=> !coinc_o);

   p_inside_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_valid_i && (hit_time_i > win_start_o) && (hit_time_i < win_stop_o) |=> coinc_o);

   if (!MERGE_REG) begin : g_comb_chk
      p_union_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !op_and_i |-> mrg_start_o <= win_start_o && mrg_start_o <= other_start_i
                    && mrg_stop_o >= win_stop_o && mrg_stop_o >= other_stop_i);

      p_inter_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         op_and_i |-> mrg_start_o >= win_start_o && mrg_start_o >= other_start_i
                   && mrg_stop_o <= win_stop_o && mrg_stop_o <= other_stop_i);

      p_overlap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !disjoint_o |-> win_start_o <= other_stop_i && other_start_i <= win_stop_o);
   end

endmodule

bind cpwin_unit cpwin_unit_chk #(
   .TIME_W   (TIME_W),
   .MERGE_REG(MERGE_REG)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .load_i       (load_i),
   .hit_valid_i  (hit_valid_i),
   .hit_time_i   (hit_time_i),
   .other_start_i(other_start_i),
   .other_stop_i (other_stop_i),
   .op_and_i     (op_and_i),
   .win_start_o  (win_start_o),
   .win_stop_o   (win_stop_o),
   .mrg_start_o  (mrg_start_o),
   .mrg_stop_o   (mrg_stop_o),
   .coinc_o      (coinc_o),
   .disjoint_o   (disjoint_o)
);

// File: tb/cpwin_unit_test.sv
`timescale 1ns/1ps
module cpwin_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic [4:0]  prof = '0;
   logic [15:0] dly = '0;
   logic        hv = 1'b0;
   logic [15:0] ht = '0;
   logic [15:0] os = '0, ot = '0;
   logic        opa = 1'b0;
   logic [15:0] ws, wt, ms, mt;
   logic        co, dj;

   int total = 0;
   int bad   = 0;
   bit seen  = 1'b0;
   bit done  = 1'b0;
   bit exp_q [$];

   always #2 clk = ~clk;

   cpwin_unit uut (
      .clk_i(clk), .rst_ni(rst_n), .load_i(load), .profile_i(prof), .delay_i(dly),
      .hit_valid_i(hv), .hit_time_i(ht), .other_start_i(os), .other_stop_i(ot),
      .op_and_i(opa), .win_start_o(ws), .win_stop_o(wt), .mrg_start_o(ms),
      .mrg_stop_o(mt), .coinc_o(co), .disjoint_o(dj)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // window load: result visible at the negedge after the capturing edge (R5)
   task automatic load_win(input logic [4:0] p, input logic [15:0] d,
                           input int es, input int et, input string req);
      @(negedge clk);
      load = 1'b1; prof = p; dly = d;
      @(negedge clk);
      load = 1'b0;
      chk({req, " start"}, ws, es);
      chk({req, " stop"},  wt, et);
   endtask

   task automatic hit(input logic [15:0] t, input bit e);
      @(negedge clk);
      hv = 1'b1; ht = t;
      exp_q.push_back(e);
      @(negedge clk);
      hv = 1'b0;
   endtask

   task automatic merge_chk(input logic [15:0] s, input logic [15:0] t, input logic a,
                            input int es, input int et, input int ed, input string req);
      @(negedge clk);
      os = s; ot = t; opa = a;
      #1;
      chk({req, " mrg_start"}, ms, es);
      chk({req, " mrg_stop"},  mt, et);
      chk("R9 disjoint", dj, ed);
   endtask

   // scoreboard monitor for the coincidence pulse (R6)
   always @(posedge clk) seen <= hv;

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (seen) begin
               if (exp_q.size() == 0) chk("R6 unexpected result", 1, 0);
               else chk("R6 coinc", co, exp_q.pop_front());
            end else if (co !== 1'b0) begin
               chk("R6 idle coinc", co, 0);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset start", ws, 0);
      chk("R10 reset stop",  wt, 0);
      chk("R10 reset coinc", co, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 after release", ws + wt + co, 0);

      load_win(5'b01000, 16'd0, 500, 1000,  "R1 bit3 first");
      load_win(5'b10000, 16'd0, 2500, 3000, "R1 bit4 last step / R3 no fall");
      load_win(5'b00000, 16'd0, 0, 3000,    "R3 empty profile");
      load_win(5'b00101, 16'd0, 1000, 1500, "R2 first fall only");
      load_win(5'b01111, 16'd0, 500, 2500,  "R2 fall on bit4");
      load_win(5'b11111, 16'd0, 500, 3000,  "R3 all ones");
      load_win(5'b11111, 16'd65000, 65500, 65535, "R4 saturation");
      load_win(5'b01000, 16'd7, 507, 1007,  "R4 delay offset");

      // R5 hold: idle cycles with a different profile must not move the window
      @(negedge clk);
      prof = 5'b10000; dly = 16'd0;
      repeat (2) @(negedge clk);
      chk("R5 hold start", ws, 507);
      chk("R5 hold stop",  wt, 1007);

      load_win(5'b01000, 16'd0, 500, 1000, "R5 reload");

      // R6 strict edges
      hit(16'd500,  1'b0);
      hit(16'd501,  1'b1);
      hit(16'd999,  1'b1);
      hit(16'd1000, 1'b0);
      hit(16'd0,    1'b0);

      // R7 / R8 / R9
      merge_chk(16'd800,  16'd2000, 1'b0, 500,  2000, 0, "R7 union");
      merge_chk(16'd800,  16'd2000, 1'b1, 800,  1000, 0, "R8 intersection");
      merge_chk(16'd1200, 16'd1500, 1'b0, 500,  1500, 1, "R7 union disjoint");
      merge_chk(16'd1200, 16'd1500, 1'b1, 1200, 1000, 1, "R8 inter disjoint");
      merge_chk(16'd100,  16'd500,  1'b1, 500,  500,  0, "R9 touching");
      merge_chk(16'd0,    16'd400,  1'b0, 0,    1000, 1, "R9 other earlier");

      // load and hit in the same cycle: hit judged on the held window (R6)
      @(negedge clk);
      load = 1'b1; prof = 5'b10000; dly = 16'd0;
      hv = 1'b1; ht = 16'd700;
      exp_q.push_back(1'b1);
      @(negedge clk);
      load = 1'b0; hv = 1'b0;
      chk("R5 same-cycle load start", ws, 2500);
      hit(16'd700,  1'b0);
      hit(16'd2600, 1'b1);

      repeat (3) @(negedge clk);
      chk("R6 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule